// File: doc/BRIEF.md
# Load/Store AXI4-Lite Data Master

This block sits between a processor core's memory stage and a 32-bit AXI4-Lite manager port. The core offers one load or store at a time on a valid/ready request interface. Each request carries a byte address, a store flag, an access width code (byte, halfword or word), a zero-extend flag and store data. The block turns the request into a single non-burst AXI4-Lite transaction. It returns the load result, or the completion of a store, as a one-cycle `done` pulse with an access-fault flag beside it.

Back-pressure on the request side works as follows. `req_ready` is high only while nothing is in flight. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low from that edge until the edge that raises `done`. The core therefore has to keep its request stable until it is taken, and cannot queue a second access. On the bus side the block keeps each address and data valid asserted, with its payload unchanged, until the subordinate's ready completes that handshake. The response channels are never stalled.

For a store, the block places the data on the correct byte lanes and computes the write strobes from the low address bits. For a load, it picks the addressed lanes out of the returned word and extends the result to 32 bits. Both sides of a response with any non-zero code raise the fault flag.

Top module: `lsu_axil_master`

## Requirements
- R1: `awaddr`/`araddr` carry the request address aligned down to the access width. `awsize`/`arsize` carry 0 for byte, 1 for halfword and 2 for word, and a request size code of 3 is handled as a word. `awprot`/`arprot` are driven to 3'b000.
- R2: Write strobes are 4'b0001 shifted left by `addr[1:0]` for a byte, 4'b0011 shifted left by 2*`addr[1]` for a halfword, and 4'b1111 for a word.
- R3: Store data is replicated onto the lanes: a byte appears in all four lanes, a halfword in both halves, and a word is passed unchanged.
- R4: A byte load returns lane `addr[1:0]` of `rdata`, and a halfword load returns half `addr[1]`. The result is sign-extended when `req_unsigned`=0 and zero-extended when it is 1. A word load returns `rdata` unchanged.
- R5: At most one access is in flight. `req_ready` is low from the acceptance edge until the cycle in which `done` is high, and a read address valid is never high together with a write address or write data valid.
- R6: For a store, `awvalid` and `wvalid` both rise in the cycle after acceptance. Each one holds with a stable payload until its own handshake and then drops independently of the other. Completion waits for `bvalid`.
- R7: For a load, `arvalid` rises in the cycle after acceptance and holds with a stable address until `arready`. Completion waits for `rvalid`.
- R8: `rsp_fault` is high in the `done` cycle exactly when the response code (`bresp` for a store, `rresp` for a load) is non-zero, and is low at all other times.
- R9: `bready` and `rready` are always high.
- R10: After reset, `req_ready` is high and `awvalid`, `wvalid`, `arvalid`, `done` and `rsp_fault` are low.
- R11: `done` is a single-cycle pulse. It is high in the cycle after the edge at which the response valid is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Zero-extend load result |
| req_wdata | input | 32 | Store data, right-justified |
| done | output | 1 | Access complete pulse |
| rsp_rdata | output | 32 | Extended load result, valid with done |
| rsp_fault | output | 1 | Access fault, valid with done |
| awaddr | output | ADDR_W | Write address |
| awsize | output | 3 | Write access width code |
| awprot | output | 3 | Write protection, fixed |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Write byte strobes |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready, tied high |
| araddr | output | ADDR_W | Read address |
| arsize | output | 3 | Read access width code |
| arprot | output | 3 | Read protection, fixed |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | 32 | Read data |
| rresp | input | 2 | Read response code |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready, tied high |

## Verification
The bench sweeps every width code against every low-address offset, with both extension modes and data whose extended bytes and halves have both signs. A lane-select or extension error then shows up as a result whose upper bits are wrong or that comes from the wrong byte. The subordinate model randomises its address, data and response delays independently. A design that waited for both address and data handshakes together, or that dropped a valid early, would therefore see its first-cycle valids or its completion timing mismatch. Every response code is injected on both paths. A fault decoder that looked at only one bit, or that kept the flag beyond the `done` cycle, is caught. Because `req_ready` is watched on every cycle an access is in flight, a block that accepted a second access early is exposed.

// File: rtl/lsu_axil_pkg.sv
package lsu_axil_pkg;
  // Access width as carried on the size field of the address channels
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  function automatic acc_size_e norm_size(input logic [1:0] code);
    case (code)
      2'd0:    return SZ_BYTE;
      2'd1:    return SZ_HALF;
      default: return SZ_WORD;
    endcase
  endfunction
endpackage

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
  import lsu_axil_pkg::*;
#(
  parameter int STRB_W = 4
) (
  input  acc_size_e                 size,
  input  logic [$clog2(STRB_W)-1:0] lane,
  input  logic [8*STRB_W-1:0]       src,
  output logic [STRB_W-1:0]         strb,
  output logic [8*STRB_W-1:0]       data
);
  localparam int LANE_W = $clog2(STRB_W);

  for (genvar i = 0; i < STRB_W; i++) begin : g_lane
    localparam logic [LANE_W-1:0] ID = LANE_W'(i);
    logic       hit;
    logic [7:0] byte_v;
    always_comb begin
      case (size)
        SZ_BYTE: begin
          hit    = (lane == ID);
          byte_v = src[7:0];
        end
        SZ_HALF: begin
          hit    = (lane[LANE_W-1] == ID[LANE_W-1]);
          byte_v = src[8*(i%2) +: 8];
        end
        default: begin
          hit    = 1'b1;
          byte_v = src[8*i +: 8];
        end
      endcase
    end
    assign strb[i]        = hit;
    assign data[8*i +: 8] = byte_v;
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_axil_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e                       size,
  input  logic [$clog2(DATA_W/8)-1:0]     lane,
  input  logic                            zero_ext,
  input  logic [DATA_W-1:0]               word,
  output logic [DATA_W-1:0]               result
);
  localparam int HALF_W = DATA_W / 2;
  localparam int LANE_W = $clog2(DATA_W/8);

  logic [7:0]        byte_v;
  logic [HALF_W-1:0] half_v;

  assign byte_v = word[8*lane +: 8];
  assign half_v = lane[LANE_W-1] ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];

  always_comb begin
    case (size)
      SZ_BYTE: result = {{(DATA_W-8){~zero_ext & byte_v[7]}}, byte_v};
      SZ_HALF: result = {{(DATA_W-HALF_W){~zero_ext & half_v[HALF_W-1]}}, half_v};
      default: result = word;
    endcase
  end
endmodule

// File: rtl/lsu_axil_master.sv
module lsu_axil_master
  import lsu_axil_pkg::*;
#(
  parameter int         ADDR_W   = 32,
  parameter logic [2:0] PROT_VAL = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [31:0]       req_wdata,
  output logic              done,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] awaddr,
  output logic [2:0]        awsize,
  output logic [2:0]        awprot,
  output logic              awvalid,
  input  logic              awready,
  output logic [31:0]       wdata,
  output logic [3:0]        wstrb,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic [ADDR_W-1:0] araddr,
  output logic [2:0]        arsize,
  output logic [2:0]        arprot,
  output logic              arvalid,
  input  logic              arready,
  input  logic [31:0]       rdata,
  input  logic [1:0]        rresp,
  input  logic              rvalid,
  output logic              rready
);
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int LANE_W = $clog2(STRB_W);

  // Latched request
  logic              busy, is_store, zext_q;
  acc_size_e         size_q;
  logic [LANE_W-1:0] lane_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q;
  logic              aw_pend, w_pend, ar_pend;

  acc_size_e         size_in;
  logic [ADDR_W-1:0] addr_aligned;
  logic              accept;
  logic [DATA_W-1:0] load_val;

  assign size_in   = norm_size(req_size);
  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;

  always_comb begin
    case (size_in)
      SZ_BYTE: addr_aligned = req_addr;
      SZ_HALF: addr_aligned = {req_addr[ADDR_W-1:1], 1'b0};
      default: addr_aligned = {req_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    endcase
  end

  lsu_store_pack #(.STRB_W(STRB_W)) u_pack (
    .size (size_q),
    .lane (lane_q),
    .src  (src_q),
    .strb (wstrb),
    .data (wdata)
  );

  lsu_load_align #(.DATA_W(DATA_W)) u_align (
    .size     (size_q),
    .lane     (lane_q),
    .zero_ext (zext_q),
    .word     (rdata),
    .result   (load_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      is_store  <= 1'b0;
      zext_q    <= 1'b0;
      size_q    <= SZ_BYTE;
      lane_q    <= '0;
      addr_q    <= '0;
      src_q     <= '0;
      aw_pend   <= 1'b0;
      w_pend    <= 1'b0;
      ar_pend   <= 1'b0;
      done      <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      done      <= 1'b0;
      rsp_fault <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        is_store <= req_store;
        zext_q   <= req_unsigned;
        size_q   <= size_in;
        lane_q   <= req_addr[LANE_W-1:0];
        addr_q   <= addr_aligned;
        src_q    <= req_wdata;
        aw_pend  <= req_store;
        w_pend   <= req_store;
        ar_pend  <= ~req_store;
      end
      if (aw_pend && awready) aw_pend <= 1'b0;
      if (w_pend  && wready)  w_pend  <= 1'b0;
      if (ar_pend && arready) ar_pend <= 1'b0;
      if (busy && is_store && bvalid) begin
        busy      <= 1'b0;
        aw_pend   <= 1'b0;
        w_pend    <= 1'b0;
        done      <= 1'b1;
        rsp_fault <= |bresp;
        rsp_rdata <= '0;
      end
      if (busy && !is_store && rvalid) begin
        busy      <= 1'b0;
        ar_pend   <= 1'b0;
        done      <= 1'b1;
        rsp_fault <= |rresp;
        rsp_rdata <= load_val;
      end
    end
  end

  assign awaddr  = addr_q;
  assign araddr  = addr_q;
  assign awsize  = {1'b0, size_q};
  assign arsize  = {1'b0, size_q};
  assign awprot  = PROT_VAL;
  assign arprot  = PROT_VAL;
  assign awvalid = aw_pend;
  assign wvalid  = w_pend;
  assign arvalid = ar_pend;
  assign bready  = 1'b1;
  assign rready  = 1'b1;

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(arvalid && (awvalid || wvalid))); // R5
  AST_NO_ACCEPT_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid || awvalid || wvalid) |-> !req_ready); // R5
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr))); // R6
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wstrb))); // R6
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> (arvalid && $stable(araddr))); // R7
  AST_STRB_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> ($countones(wstrb) == (1 << awsize))); // R2
  AST_AWADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> ((awsize == 3'd2) ? (awaddr[1:0] == 2'b00) :
                 (awsize == 3'd1) ? !awaddr[0] : 1'b1)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> done); // R8
endmodule

// File: tb/lsu_axil_master_tb_top.sv
module lsu_axil_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_ready, req_store, req_unsigned;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        done, rsp_fault;
  logic [31:0] rsp_rdata;
  logic [31:0] awaddr, araddr, wdata, rdata;
  logic [2:0]  awsize, awprot, arsize, arprot;
  logic        awvalid, awready, wvalid, wready, bvalid, bready;
  logic        arvalid, arready, rvalid, rready;
  logic [3:0]  wstrb;
  logic [1:0]  bresp, rresp;

  lsu_axil_master dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_store(req_store), .req_size(req_size), .req_unsigned(req_unsigned),
    .req_wdata(req_wdata), .done(done), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
    .awaddr(awaddr), .awsize(awsize), .awprot(awprot), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arsize(arsize), .arprot(arprot), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Subordinate model: drives on falling edges
  logic [31:0] mem [16];
  bit          got_aw, got_w, got_ar;
  logic [31:0] cap_awaddr, cap_wdata, cap_araddr;
  logic [2:0]  cap_awsize, cap_awprot, cap_arsize, cap_arprot;
  logic [3:0]  cap_wstrb;
  int          b_delay, r_delay;
  logic [1:0]  inj_resp;

  initial begin
    awready = 0; wready = 0; arready = 0;
    bvalid = 0; rvalid = 0; bresp = 0; rresp = 0; rdata = 0;
    got_aw = 0; got_w = 0; got_ar = 0; b_delay = 0; r_delay = 0; inj_resp = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (bvalid) begin
          bvalid = 0; bresp = 0;
        end else if (got_aw && got_w) begin
          if (b_delay > 0) b_delay--;
          else begin
            for (int k = 0; k < 4; k++)
              if (cap_wstrb[k]) mem[cap_awaddr[5:2]][8*k +: 8] = cap_wdata[8*k +: 8];
            bvalid = 1; bresp = inj_resp; got_aw = 0; got_w = 0;
          end
        end
        if (rvalid) begin
          rvalid = 0; rresp = 0; rdata = 32'hDEAD_BEEF;
        end else if (got_ar) begin
          if (r_delay > 0) r_delay--;
          else begin
            rvalid = 1; rresp = inj_resp; rdata = mem[cap_araddr[5:2]]; got_ar = 0;
          end
        end
        awready = (awvalid && !got_aw) ? (($urandom % 3) != 0) : 1'b0;
        if (awvalid && awready) begin
          got_aw = 1; cap_awaddr = awaddr; cap_awsize = awsize; cap_awprot = awprot;
          b_delay = $urandom % 3;
        end
        wready = (wvalid && !got_w) ? (($urandom % 3) != 0) : 1'b0;
        if (wvalid && wready) begin
          got_w = 1; cap_wdata = wdata; cap_wstrb = wstrb;
        end
        arready = (arvalid && !got_ar) ? (($urandom % 3) != 0) : 1'b0;
        if (arvalid && arready) begin
          got_ar = 1; cap_araddr = araddr; cap_arsize = arsize; cap_arprot = arprot;
          r_delay = $urandom % 3;
        end
      end
    end
  end

  // Observation point a quarter period after the rising edge
  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  function automatic logic [31:0] exp_align(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'd0) return a;
    if (sz == 2'd1) return {a[31:1], 1'b0};
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic [3:0] exp_strb(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'd0) return 4'b0001 << a[1:0];
    if (sz == 2'd1) return 4'b0011 << (2 * a[1]);
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wdata(input logic [31:0] d, input logic [1:0] sz);
    if (sz == 2'd0) return {4{d[7:0]}};
    if (sz == 2'd1) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] w, input logic [31:0] a,
                                           input logic [1:0] sz, input bit uns);
    logic [31:0] s;
    if (sz == 2'd0) begin
      s = w >> (8 * a[1:0]);
      return uns ? {24'h0, s[7:0]} : {{24{s[7]}}, s[7:0]};
    end
    if (sz == 2'd1) begin
      s = w >> (16 * a[1]);
      return uns ? {16'h0, s[15:0]} : {{16{s[15]}}, s[15:0]};
    end
    return w;
  endfunction

  task automatic access(input bit st, input logic [1:0] sz, input logic [31:0] a,
                        input bit uns, input logic [31:0] wd, input logic [1:0] resp);
    logic [31:0] exp_ld;
    int t;
    logic [2:0] esz;
    esz = (sz == 2'd3) ? 3'd2 : {1'b0, sz};
    exp_ld = exp_load(mem[a[5:2]], a, sz, uns);
    inj_resp = resp;
    req_valid = 1; req_store = st; req_size = sz; req_addr = a;
    req_unsigned = uns; req_wdata = wd;
    t = 0;
    while (!req_ready && t < 100) begin step(); t++; end
    step();
    req_valid = 0;
    if (st) check(awvalid && wvalid && !arvalid, "R6 store valids after accept",
                  {29'h0, awvalid, wvalid, arvalid}, 32'h6);
    else    check(arvalid && !awvalid && !wvalid, "R7 load valid after accept",
                  {29'h0, awvalid, wvalid, arvalid}, 32'h1);
    t = 0;
    while (!done && t < 100) begin
      check(!req_ready, "R5 ready low while in flight", {31'h0, req_ready}, 32'h0);
      check(!(arvalid && (awvalid || wvalid)), "R5 read and write valids together",
            {29'h0, awvalid, wvalid, arvalid}, 32'h0);
      check(bready && rready, "R9 response readies high", {30'h0, bready, rready}, 32'h3);
      step(); t++;
    end
    check(done, "R5 completion reached", {31'h0, done}, 32'h1);
    check(req_ready, "R5 ready high in done cycle", {31'h0, req_ready}, 32'h1);
    check(st ? bvalid : rvalid, "R11 done one cycle after response", {31'h0, st ? bvalid : rvalid}, 32'h1);
    check(rsp_fault == (resp != 2'b00), "R8 fault flag", {31'h0, rsp_fault}, {31'h0, resp != 2'b00});
    if (st) begin
      check(cap_awaddr == exp_align(a, sz), "R1 write address aligned", cap_awaddr, exp_align(a, sz));
      check(cap_awsize == esz, "R1 write size code", {29'h0, cap_awsize}, {29'h0, esz});
      check(cap_awprot == 3'b000, "R1 write prot", {29'h0, cap_awprot}, 32'h0);
      check(cap_wstrb == exp_strb(a, sz), "R2 write strobes", {28'h0, cap_wstrb}, {28'h0, exp_strb(a, sz)});
      check(cap_wdata == exp_wdata(wd, sz), "R3 write data lanes", cap_wdata, exp_wdata(wd, sz));
    end else begin
      check(cap_araddr == exp_align(a, sz), "R1 read address aligned", cap_araddr, exp_align(a, sz));
      check(cap_arsize == esz, "R1 read size code", {29'h0, cap_arsize}, {29'h0, esz});
      check(cap_arprot == 3'b000, "R1 read prot", {29'h0, cap_arprot}, 32'h0);
      check(rsp_rdata == exp_ld, "R4 load result", rsp_rdata, exp_ld);
    end
    step();
    check(!done, "R11 done single cycle", {31'h0, done}, 32'h0);
    check(!rsp_fault, "R8 fault cleared after done", {31'h0, rsp_fault}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    mem[0] = 32'hF18E_6C93;
    mem[1] = 32'h0E71_9B2C;
    rst_n = 0; req_valid = 0; req_store = 0; req_size = 0;
    req_addr = 0; req_unsigned = 0; req_wdata = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    // R10 reset state
    check(req_ready, "R10 ready after reset", {31'h0, req_ready}, 32'h1);
    check(!awvalid && !wvalid && !arvalid, "R10 valids low after reset",
          {29'h0, awvalid, wvalid, arvalid}, 32'h0);
    check(!done && !rsp_fault, "R10 done and fault low after reset", {30'h0, done, rsp_fault}, 32'h0);
    check(bready && rready, "R9 readies high after reset", {30'h0, bready, rready}, 32'h3);

    // Sweep: direction x size code x offset x extension x pattern
    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int un = 0; un < 2; un++)
            for (int p = 0; p < 2; p++) begin
              if (st == 1)
                access(1'b1, 2'(sz), 32'h1000_0020 | 32'(off), un[0],
                       p[0] ? 32'h8A9B_C7D5 : 32'h1234_5678, 2'b00);
              else
                access(1'b0, 2'(sz), 32'h2000_0000 | (32'(p) << 2) | 32'(off), un[0],
                       32'h0, 2'b00);
            end

    // Fault injection on both paths, all non-zero codes
    for (int r = 1; r < 4; r++) begin
      access(1'b1, 2'd2, 32'h1000_0024, 1'b0, 32'hCAFE_F00D, 2'(r));
      access(1'b0, 2'd0, 32'h2000_0003, 1'b0, 32'h0, 2'(r));
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog actual=hung expected=completion");
    finish_run();
  end
endmodule